// File: doc/BRIEF.md
# Phase-Locked Multi-Channel Square-Wave Generator

This block produces several square waves that share one frequency and keep fixed phase offsets from one another. The main use is a quadrature pair, 0 and 90 degrees, and more channels can be added. Each channel owns a phase accumulator. The full range of the accumulator stands for one turn, so a quarter of that range (0x40000000 at 32 bits) is 90 degrees. On every clock, every channel adds the same active frequency word, and each output is the top bit of its accumulator. With an 80 MHz clock the increment for an output frequency f is about 53.7 times f, and 10 to 20 kHz is the intended range.

Software-style writes go to shadow registers: the frequency word and one start offset per non-reference channel. An update strobe moves all shadow values into the active set on one edge. Because of this, a retune reaches every channel on the same cycle and the phase differences do not drift. A start strobe loads every accumulator on one common edge and sets the generator running. A resync strobe realigns a running generator to newly activated offsets. A global enable gates every output low.

Top module: `phase_nco`

## Requirements
- R1: After reset all accumulators, shadow and active registers are zero, the generator is idle and every output is low.
- R2: A write with wr_addr 0 sets the shadow frequency word and a write with wr_addr i (1 to NUM_CH-1) sets channel i's shadow offset. Addresses at or above NUM_CH are ignored. Shadow writes have no effect on the outputs until an update.
- R3: An update strobe copies every shadow value, as held before that edge, into the active registers on one edge. Accumulation uses the new word from the following edge on.
- R4: A start strobe loads channel 0 with zero and channel i with its active offset, and sets the generator running. Before the first start, the accumulators hold their value.
- R5: While running, and with no start or resync, every accumulator adds the active frequency word on every edge, wrapping modulo 2^ACC_W.
- R6: Output i equals the most significant bit of accumulator i when out_en is 1, and is 0 when out_en is 0.
- R7: A resync strobe while running sets channel 0 to its normal next value (acc0 + freq) and channel i to that same value plus its active offset, all on one edge.
- R8: Start takes priority over resync in the same cycle. A resync while idle changes nothing.
- R9: An active frequency word of zero holds every output static.
- R10: While running, the difference between any channel's accumulator and channel 0's stays constant across cycles without start or resync, including across frequency updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | 0 = frequency word, i = offset of channel i |
| wr_data | input | ACC_W | Write data |
| start | input | 1 | Load all accumulators and begin running |
| update | input | 1 | Copy shadow registers to active registers |
| resync | input | 1 | Realign running channels to the active offsets |
| out_en | input | 1 | Global output enable |
| wave_out | output | NUM_CH | Square-wave outputs, bit i is channel i |

## Verification
The bench builds the block with NUM_CH = 3 and ACC_W = 12. The 12-bit accumulator makes wraps and full output periods happen within a few cycles. A quarter-range offset of 0x400 then gives an exact 4-cycle quadrature pattern, and a third channel at 0x800 adds a 180-degree reference. These settings put retuning in mid-period, resync onto changed offsets and the start/resync collision all within short runs, and every output bit is checked against a per-cycle model of the requirements.

// File: rtl/phase_nco.sv
module phase_nco #(
  parameter int NUM_CH = 4,
  parameter int ACC_W  = 32,
  parameter int AW     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [ACC_W-1:0]  wr_data,
  input  logic              start,
  input  logic              update,
  input  logic              resync,
  input  logic              out_en,
  output logic [NUM_CH-1:0] wave_out
);

  localparam int MSB = ACC_W - 1;

  logic [ACC_W-1:0] freq_sh, freq_act;
  logic [ACC_W-1:0] off_sh  [NUM_CH];
  logic [ACC_W-1:0] off_act [NUM_CH];
  logic [ACC_W-1:0] acc     [NUM_CH];
  logic             running;

  logic [ACC_W-1:0] ref_next;
  assign ref_next = acc[0] + freq_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_sh  <= '0;
      freq_act <= '0;
      running  <= 1'b0;
      for (int i = 0; i < NUM_CH; i++) begin
        off_sh[i]  <= '0;
        off_act[i] <= '0;
        acc[i]     <= '0;
      end
    end else begin
      running <= running | start;
      if (wr_en && wr_addr == '0) freq_sh <= wr_data;
      if (update) freq_act <= freq_sh;
      if (start)        acc[0] <= '0;
      else if (running) acc[0] <= ref_next;
      off_sh[0]  <= '0;
      off_act[0] <= '0;
      for (int i = 1; i < NUM_CH; i++) begin
        if (wr_en && wr_addr == AW'(i)) off_sh[i] <= wr_data;
        if (update) off_act[i] <= off_sh[i];
        if (start)                  acc[i] <= off_act[i];
        else if (running && resync) acc[i] <= ref_next + off_act[i];
        else if (running)           acc[i] <= acc[i] + freq_act;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_CH; i++)
      wave_out[i] = out_en & acc[i][MSB];
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (wave_out == '0));

  // R3
  update_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update |=> (freq_act == $past(freq_sh)));

  // R4
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (acc[0] == '0 && running));

  // R5
  run_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !start && !resync) |=> (acc[0] == $past(acc[0] + freq_act)));

  // R8
  idle_resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> $stable(acc[0]));

  for (genvar g = 1; g < NUM_CH; g++) begin : g_phase
    // R10
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !start && !resync) |=>
        ((acc[g] - acc[0]) == $past(acc[g] - acc[0])));
    // R7
    resync_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running && resync && !start) |=>
        ((acc[g] - acc[0]) == $past(off_act[g])));
  end

endmodule

// File: tb/phase_nco_bench.sv
module phase_nco_bench;
  localparam int NUM_CH = 3;
  localparam int ACC_W  = 12;
  localparam int AW     = 2;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, start = 0, update = 0, resync = 0, out_en = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [ACC_W-1:0] wr_data = '0;
  logic [NUM_CH-1:0] wave_out;

  always #2 clk = ~clk;

  phase_nco #(.NUM_CH(NUM_CH), .ACC_W(ACC_W), .AW(AW)) u_phase_nco (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .start(start), .update(update), .resync(resync),
    .out_en(out_en), .wave_out(wave_out));

  typedef struct { logic [NUM_CH-1:0] exp; string tag; } item_t;
  item_t sb[$];
  int tests = 0, fails = 0;
  bit done = 0;

  logic [ACC_W-1:0] m_fsh = '0, m_f = '0;
  logic [ACC_W-1:0] m_osh [NUM_CH];
  logic [ACC_W-1:0] m_off [NUM_CH];
  logic [ACC_W-1:0] m_acc [NUM_CH];
  bit m_run = 0;

  bit d_wr = 0, d_st = 0, d_up = 0, d_rs = 0, d_oe = 0;
  int d_addr = 0;
  logic [ACC_W-1:0] d_data = '0;

  task automatic tick(string tag);
    logic [ACC_W-1:0] a0;
    item_t it;
    @(negedge clk); #1;
    wr_en = d_wr; wr_addr = AW'(d_addr); wr_data = d_data;
    start = d_st; update = d_up; resync = d_rs; out_en = d_oe;
    @(posedge clk); #1;
    a0 = m_acc[0];
    if (d_st) begin
      m_acc[0] = '0;
      for (int i = 1; i < NUM_CH; i++) m_acc[i] = m_off[i];
    end else if (m_run) begin
      m_acc[0] = a0 + m_f;
      for (int i = 1; i < NUM_CH; i++)
        m_acc[i] = d_rs ? a0 + m_f + m_off[i] : m_acc[i] + m_f;
    end
    if (d_st) m_run = 1;
    if (d_up) begin
      m_f = m_fsh;
      for (int i = 1; i < NUM_CH; i++) m_off[i] = m_osh[i];
    end
    if (d_wr) begin
      if (d_addr == 0) m_fsh = d_data;
      else if (d_addr < NUM_CH) m_osh[d_addr] = d_data;
    end
    for (int i = 0; i < NUM_CH; i++) it.exp[i] = d_oe & m_acc[i][ACC_W-1];
    it.tag = tag;
    sb.push_back(it);
    d_wr = 0; d_st = 0; d_up = 0; d_rs = 0;
  endtask

  task automatic wreg(int a, logic [ACC_W-1:0] v, string tag);
    d_wr = 1; d_addr = a; d_data = v; tick(tag);
  endtask

  task automatic run(int n, string tag);
    for (int k = 0; k < n; k++) tick(tag);
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      tests++;
      if (wave_out !== it.exp) begin
        fails++;
        $display("FAIL %s: wave_out=%b expected=%b", it.tag, wave_out, it.exp);
      end
    end
  end

  initial begin
    for (int i = 0; i < NUM_CH; i++) begin m_osh[i] = '0; m_off[i] = '0; m_acc[i] = '0; end
    repeat (3) @(negedge clk);
    tests++;
    if (wave_out !== '0) begin fails++; $display("FAIL R1: wave_out=%b expected=0", wave_out); end
    rst_n = 1;
    d_oe = 1;
    run(3, "R1");
    d_rs = 1; tick("R8"); run(2, "R8");
    wreg(0, 12'h400, "R2"); wreg(1, 12'h400, "R2"); wreg(2, 12'h800, "R2");
    wreg(3, 12'h123, "R2");
    d_st = 1; tick("R2"); run(4, "R2");
    d_up = 1; tick("R3"); run(2, "R3");
    d_st = 1; tick("R4"); run(8, "R5");
    wreg(0, 12'h0A3, "R10"); d_up = 1; tick("R10"); run(30, "R10");
    d_oe = 0; run(6, "R6"); d_oe = 1; run(4, "R6");
    wreg(1, 12'h200, "R7"); wreg(2, 12'h900, "R7"); d_up = 1; tick("R7");
    run(5, "R7"); d_rs = 1; tick("R7"); run(20, "R7");
    d_st = 1; d_rs = 1; tick("R8"); run(10, "R8");
    wreg(0, 12'h000, "R9"); d_up = 1; tick("R9"); run(12, "R9");
    wreg(0, 12'h7FF, "R5"); d_up = 1; tick("R5"); run(25, "R5");
    wreg(0, 12'h9C5, "R10"); d_up = 1; tick("R10"); run(25, "R10");
    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule